// File: doc/BRIEF.md
# Scatter-Gather Descriptor DMA Engine

This block moves data from card memory to host memory by walking a table of transfer descriptors that sit back to back in host memory. Software writes the table, places the table's address on `base_addr` and pulses `start`. The engine then reads one descriptor at a time over a simple 32-bit word read port. Each descriptor is three words: a source address, a destination address and a control word that holds a byte count and an end-of-table flag.

For each descriptor the engine checks the byte count. It then issues one data-mover request for every 256-byte burst in the count, advancing both addresses by 256 after each burst. After the descriptor that carries the end flag has finished, it gives a one-cycle `done` pulse. A malformed count, or a bus error reported by the data mover on its read or write side, ends the walk early and sets a matching status flag. Words are taken as little-endian: byte lane 0 of `desc_rdata` holds the lowest-addressed byte, and no byte swapping is done.

Top module: `sgdma_engine`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after that edge, `busy`, `done`, `err_sg`, `err_rd`, `err_wr`, `desc_req` and `mv_req` are all 0.
- R2: A `start` pulse while idle latches `base_addr`, raises `busy` and clears all three error flags. Descriptor k is fetched from word addresses base+12k, base+12k+4 and base+12k+8, in that order.
- R3: In the control word, bits [17:0] are the byte count and bit 31 is the end flag. Bits [30:18] have no effect on the transfer.
- R4: A legal descriptor with count C produces exactly C/256 data-mover requests. The n-th request (from 0) carries source src+256n and destination dst+256n. Requests keep table order across descriptors.
- R5: After the last burst of a descriptor with the end flag is acknowledged without error, `done` is high for exactly one cycle, and in that cycle `busy` is already 0. Without the end flag, the engine goes on to the next descriptor.
- R6: A count of zero, or a count with any of bits [7:0] set, makes that descriptor issue no request. It sets `err_sg`, drops `busy` and gives no `done` pulse.
- R7: A data-mover acknowledge with `mv_rd_err` high sets `err_rd`, ends the walk with no further request and gives no `done`.
- R8: A data-mover acknowledge with `mv_wr_err` high sets `err_wr`, ends the walk with no further request and gives no `done`.
- R9: A `start` pulse while `busy` is high is ignored. The walk in progress keeps its base address and request sequence.
- R10: The error flags stay set while idle until the next accepted `start`.
- R11: `desc_req` and `mv_req`, once raised, stay high with a stable address (and stable source and destination) until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request to begin a table walk |
| base_addr | input | 32 | Byte address of the first descriptor |
| busy | output | 1 | High from an accepted start until completion or abort |
| done | output | 1 | One-cycle completion pulse after the end-flagged descriptor |
| err_sg | output | 1 | Malformed descriptor seen |
| err_rd | output | 1 | Data-mover read-side error seen |
| err_wr | output | 1 | Data-mover write-side error seen |
| desc_req | output | 1 | Descriptor word read request |
| desc_addr | output | 32 | Byte address of the requested descriptor word |
| desc_ack | input | 1 | Read acknowledge; `desc_rdata` valid in this cycle |
| desc_rdata | input | 32 | Descriptor word, little-endian |
| mv_req | output | 1 | 256-byte burst request to the data mover |
| mv_src | output | 32 | Burst source address in card memory |
| mv_dst | output | 32 | Burst destination address in host memory |
| mv_ack | input | 1 | Burst finished |
| mv_rd_err | input | 1 | With `mv_ack`: the read side failed |
| mv_wr_err | input | 1 | With `mv_ack`: the write side failed |

## Verification
The bench goes after counts at the edges of the legal range: a single burst, the largest count of 0x3FF00 (a design that drops a top count bit would issue far fewer bursts), zero, and a count off the 256 grid (a design that rounds instead of rejecting would move data and raise `done`). It sets random reserved control bits, which would change a count or end decision if the field slicing were wrong. It also leaves off the end flag so the walk must run into an all-zero descriptor and abort. A bus error is injected at a random burst, and a second start is pulsed mid-walk. A design that kept going after a fault, or that took the new base, shows extra or misplaced requests in the logged sequence.

// File: rtl/sgdma_pkg.sv
// Shared constants and types for the scatter-gather DMA engine.
// Assumes a fixed three-word descriptor of 32-bit words.
package sgdma_pkg;
    localparam int unsigned WORD_BYTES = 4;
    localparam int unsigned ELEM_WORDS = 3;
    localparam int unsigned ELEM_BYTES = WORD_BYTES * ELEM_WORDS;
    localparam int unsigned LAST_BIT   = 31;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FGO   = 2'd1,
        ST_FWAIT = 2'd2,
        ST_MOVE  = 2'd3
    } walk_state_t;
endpackage

// File: rtl/sgdma_fetch.sv
// Descriptor fetch unit: on go, reads ELEM_WORDS consecutive words starting
// at ptr over a request/acknowledge port and presents the decoded element
// with a one-cycle valid pulse. Assumes ptr is stable while fetching.
module sgdma_fetch
    import sgdma_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [AW-1:0]    ptr,
    output logic             desc_req,
    output logic [AW-1:0]    desc_addr,
    input  logic             desc_ack,
    input  logic [31:0]      desc_rdata,
    output logic             elem_vld,
    output logic [AW-1:0]    elem_src,
    output logic [AW-1:0]    elem_dst,
    output logic [CNT_W-1:0] elem_cnt,
    output logic             elem_last
);
    localparam int unsigned IDX_W = $clog2(ELEM_WORDS);

    logic             active;
    logic [IDX_W-1:0] idx;

    // Address of the word currently requested.
    always_comb desc_addr = ptr + (AW'(idx) << 2);
    assign desc_req = active;

    // Sequence through the words of one element and capture each field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            idx       <= '0;
            elem_vld  <= 1'b0;
            elem_src  <= '0;
            elem_dst  <= '0;
            elem_cnt  <= '0;
            elem_last <= 1'b0;
        end else begin
            elem_vld <= 1'b0;
            if (go) begin
                active <= 1'b1;
                idx    <= '0;
            end else if (active && desc_ack) begin
                case (idx)
                    IDX_W'(0): elem_src <= desc_rdata[AW-1:0];
                    IDX_W'(1): elem_dst <= desc_rdata[AW-1:0];
                    default: begin
                        elem_cnt  <= desc_rdata[CNT_W-1:0];
                        elem_last <= desc_rdata[LAST_BIT];
                    end
                endcase
                if (idx == IDX_W'(ELEM_WORDS - 1)) begin
                    active   <= 1'b0;
                    elem_vld <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    AST_DESC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_req && !desc_ack) |=> (desc_req && $stable(desc_addr))); // R11
endmodule

// File: rtl/sgdma_burst.sv
// Burst issuer: splits one validated element into BURST_BYTES bursts,
// presenting each to the data mover until acknowledged. Reports normal
// finish or a read/write fault as one-cycle pulses. Assumes cnt is a
// nonzero multiple of BURST_BYTES when go is pulsed.
module sgdma_burst #(
    parameter int unsigned AW          = 32,
    parameter int unsigned CNT_W       = 18,
    parameter int unsigned BURST_BYTES = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [AW-1:0]    src,
    input  logic [AW-1:0]    dst,
    input  logic [CNT_W-1:0] cnt,
    output logic             mv_req,
    output logic [AW-1:0]    mv_src,
    output logic [AW-1:0]    mv_dst,
    input  logic             mv_ack,
    input  logic             mv_rd_err,
    input  logic             mv_wr_err,
    output logic             fin,
    output logic             rd_fault,
    output logic             wr_fault
);
    localparam int unsigned BSH   = $clog2(BURST_BYTES);
    localparam int unsigned LEFT_W = CNT_W - BSH;

    logic              active;
    logic [LEFT_W-1:0] left;
    logic              bad;

    assign mv_req = active;
    assign bad    = mv_rd_err || mv_wr_err;

    // Count down bursts, step addresses, stop on fault or last burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            left     <= '0;
            mv_src   <= '0;
            mv_dst   <= '0;
            fin      <= 1'b0;
            rd_fault <= 1'b0;
            wr_fault <= 1'b0;
        end else begin
            fin      <= 1'b0;
            rd_fault <= 1'b0;
            wr_fault <= 1'b0;
            if (go) begin
                active <= 1'b1;
                left   <= cnt[CNT_W-1:BSH];
                mv_src <= src;
                mv_dst <= dst;
            end else if (active && mv_ack) begin
                if (bad) begin
                    active   <= 1'b0;
                    rd_fault <= mv_rd_err;
                    wr_fault <= mv_wr_err;
                end else if (left == LEFT_W'(1)) begin
                    active <= 1'b0;
                    fin    <= 1'b1;
                end else begin
                    left   <= left - 1'b1;
                    mv_src <= mv_src + AW'(BURST_BYTES);
                    mv_dst <= mv_dst + AW'(BURST_BYTES);
                end
            end
        end
    end

    AST_MV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_req && !mv_ack) |=> (mv_req && $stable(mv_src) && $stable(mv_dst))); // R11
    AST_FAULT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_req && mv_ack && bad) |=> !mv_req); // R7
endmodule

// File: rtl/sgdma_ctrl.sv
// Walk controller: accepts start while idle, steps the element pointer,
// validates each fetched count, launches bursts and ends the walk on the
// end flag, a malformed element or a data-mover fault.
// Assumes fetch fields stay stable from elem_vld until the next fetch.
module sgdma_ctrl
    import sgdma_pkg::*;
#(
    parameter int unsigned AW          = 32,
    parameter int unsigned CNT_W       = 18,
    parameter int unsigned BURST_BYTES = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW-1:0]    base_addr,
    input  logic             elem_vld,
    input  logic [CNT_W-1:0] elem_cnt,
    input  logic             elem_last,
    input  logic             fin,
    input  logic             rd_fault,
    input  logic             wr_fault,
    output logic             fetch_go,
    output logic [AW-1:0]    fetch_ptr,
    output logic             move_go,
    output logic             busy,
    output logic             done,
    output logic             err_sg,
    output logic             err_rd,
    output logic             err_wr
);
    localparam int unsigned BSH = $clog2(BURST_BYTES);

    walk_state_t state;
    logic        legal;
    logic        last_q;

    // Count must be nonzero and sit on the burst grid.
    always_comb legal = (elem_cnt != '0) && (elem_cnt[BSH-1:0] == '0);

    assign busy     = (state != ST_IDLE);
    assign fetch_go = (state == ST_FGO);

    // Walk state machine with pointer, status flags and pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            fetch_ptr <= '0;
            move_go   <= 1'b0;
            last_q    <= 1'b0;
            done      <= 1'b0;
            err_sg    <= 1'b0;
            err_rd    <= 1'b0;
            err_wr    <= 1'b0;
        end else begin
            move_go <= 1'b0;
            done    <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    fetch_ptr <= base_addr;
                    err_sg    <= 1'b0;
                    err_rd    <= 1'b0;
                    err_wr    <= 1'b0;
                    state     <= ST_FGO;
                end
                ST_FGO: state <= ST_FWAIT;
                ST_FWAIT: if (elem_vld) begin
                    if (legal) begin
                        move_go <= 1'b1;
                        last_q  <= elem_last;
                        state   <= ST_MOVE;
                    end else begin
                        err_sg <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                ST_MOVE: begin
                    if (rd_fault || wr_fault) begin
                        err_rd <= rd_fault;
                        err_wr <= wr_fault;
                        state  <= ST_IDLE;
                    end else if (fin) begin
                        if (last_q) begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            fetch_ptr <= fetch_ptr + AW'(ELEM_BYTES);
                            state     <= ST_FGO;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R5
    AST_SG_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_sg) |-> (!done && !busy)); // R6
    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !err_sg && !err_rd && !err_wr)); // R2
    AST_PTR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && state != ST_MOVE) |=> $stable(fetch_ptr)); // R9
endmodule

// File: rtl/sgdma_engine.sv
// Top of the scatter-gather DMA engine: wires the walk controller, the
// descriptor fetch unit and the burst issuer together.
// Assumes a single outstanding request on each of the two ports.
module sgdma_engine #(
    parameter int unsigned AW          = 32,
    parameter int unsigned CNT_W       = 18,
    parameter int unsigned BURST_BYTES = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] base_addr,
    output logic          busy,
    output logic          done,
    output logic          err_sg,
    output logic          err_rd,
    output logic          err_wr,
    output logic          desc_req,
    output logic [AW-1:0] desc_addr,
    input  logic          desc_ack,
    input  logic [31:0]   desc_rdata,
    output logic          mv_req,
    output logic [AW-1:0] mv_src,
    output logic [AW-1:0] mv_dst,
    input  logic          mv_ack,
    input  logic          mv_rd_err,
    input  logic          mv_wr_err
);
    logic             fetch_go;
    logic [AW-1:0]    fetch_ptr;
    logic             elem_vld;
    logic [AW-1:0]    elem_src;
    logic [AW-1:0]    elem_dst;
    logic [CNT_W-1:0] elem_cnt;
    logic             elem_last;
    logic             move_go;
    logic             fin;
    logic             rd_fault;
    logic             wr_fault;

    sgdma_ctrl #(.AW(AW), .CNT_W(CNT_W), .BURST_BYTES(BURST_BYTES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .elem_vld(elem_vld), .elem_cnt(elem_cnt), .elem_last(elem_last),
        .fin(fin), .rd_fault(rd_fault), .wr_fault(wr_fault),
        .fetch_go(fetch_go), .fetch_ptr(fetch_ptr), .move_go(move_go),
        .busy(busy), .done(done), .err_sg(err_sg), .err_rd(err_rd),
        .err_wr(err_wr)
    );

    sgdma_fetch #(.AW(AW), .CNT_W(CNT_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .go(fetch_go), .ptr(fetch_ptr),
        .desc_req(desc_req), .desc_addr(desc_addr), .desc_ack(desc_ack),
        .desc_rdata(desc_rdata), .elem_vld(elem_vld), .elem_src(elem_src),
        .elem_dst(elem_dst), .elem_cnt(elem_cnt), .elem_last(elem_last)
    );

    sgdma_burst #(.AW(AW), .CNT_W(CNT_W), .BURST_BYTES(BURST_BYTES)) u_burst (
        .clk(clk), .rst_n(rst_n), .go(move_go), .src(elem_src),
        .dst(elem_dst), .cnt(elem_cnt), .mv_req(mv_req), .mv_src(mv_src),
        .mv_dst(mv_dst), .mv_ack(mv_ack), .mv_rd_err(mv_rd_err),
        .mv_wr_err(mv_wr_err), .fin(fin), .rd_fault(rd_fault),
        .wr_fault(wr_fault)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!desc_req && !mv_req)); // R9
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !desc_req && !mv_req)); // R1
endmodule

// File: tb/sim_sgdma_engine.sv
// Self-checking bench: random descriptor tables plus directed corners.
module sim_sgdma_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] base_addr = '0;
    logic        busy, done, err_sg, err_rd, err_wr;
    logic        desc_req, desc_ack = 1'b0;
    logic [31:0] desc_addr, desc_rdata = '0;
    logic        mv_req, mv_ack = 1'b0, mv_rd_err = 1'b0, mv_wr_err = 1'b0;
    logic [31:0] mv_src, mv_dst;

    always #5 clk = ~clk;

    sgdma_engine u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .busy(busy), .done(done), .err_sg(err_sg), .err_rd(err_rd),
        .err_wr(err_wr), .desc_req(desc_req), .desc_addr(desc_addr),
        .desc_ack(desc_ack), .desc_rdata(desc_rdata), .mv_req(mv_req),
        .mv_src(mv_src), .mv_dst(mv_dst), .mv_ack(mv_ack),
        .mv_rd_err(mv_rd_err), .mv_wr_err(mv_wr_err)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [31:0] mem [0:63];
    logic [31:0] cur_base;
    logic [31:0] exp_src [0:2047];
    logic [31:0] exp_dst [0:2047];
    int exp_n, exp_done;
    logic exp_sg, exp_rd, exp_wr;
    int err_at, err_kind;
    int fetch_n, burst_n, done_n, d_dly, m_dly;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rd_mem(input logic [31:0] a);
        logic [31:0] i;
        i = (a - cur_base) >> 2;
        return (i < 64) ? mem[i[5:0]] : 32'h0;
    endfunction

    // Watchdog: a hung run is a failed check and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            checks++; fails++;
            $display("FAIL watchdog act=%0d exp<190000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Descriptor memory responder; checks fetch address order (R2).
    always @(negedge clk) begin
        if (desc_ack) desc_ack = 1'b0;
        else if (desc_req && rst_n) begin
            if (d_dly > 0) d_dly--;
            else begin
                chk(desc_addr == cur_base + 32'(4 * fetch_n), "R2", "desc_addr",
                    desc_addr, cur_base + 32'(4 * fetch_n));
                desc_rdata = rd_mem(desc_addr);
                desc_ack = 1'b1;
                fetch_n++;
                d_dly = $urandom % 3;
            end
        end
    end

    // Data-mover responder; checks burst sequence (R4), injects faults.
    always @(negedge clk) begin
        if (mv_ack) begin
            mv_ack = 1'b0; mv_rd_err = 1'b0; mv_wr_err = 1'b0;
        end else if (mv_req && rst_n) begin
            if (m_dly > 0) m_dly--;
            else begin
                chk(burst_n < exp_n, "R4", "burst count overrun", 32'(burst_n), 32'(exp_n));
                if (burst_n < exp_n && burst_n < 2048) begin
                    chk(mv_src == exp_src[burst_n], "R4", "mv_src", mv_src, exp_src[burst_n]);
                    chk(mv_dst == exp_dst[burst_n], "R4", "mv_dst", mv_dst, exp_dst[burst_n]);
                end
                if (burst_n == err_at) begin
                    mv_rd_err = (err_kind == 1);
                    mv_wr_err = (err_kind == 2);
                end
                mv_ack = 1'b1;
                burst_n++;
                m_dly = $urandom % 4;
            end
        end
    end

    // Done monitor: pulse coincides with busy low (R5).
    always @(negedge clk) begin
        if (done && rst_n) begin
            done_n++;
            chk(!busy, "R5", "busy during done", 32'(busy), 32'h0);
        end
    end

    // Reference walk of the table from the requirements.
    task automatic model();
        int g;
        logic [31:0] s, d, c;
        bit stop;
        g = 0; stop = 0;
        exp_done = 0; exp_sg = 0; exp_rd = 0; exp_wr = 0;
        for (int e = 0; e < 21 && !stop; e++) begin
            s = (3*e   < 64) ? mem[3*e]   : 32'h0;
            d = (3*e+1 < 64) ? mem[3*e+1] : 32'h0;
            c = (3*e+2 < 64) ? mem[3*e+2] : 32'h0;
            if (c[17:0] == 18'h0 || c[7:0] != 8'h0) begin
                exp_sg = 1; stop = 1;
            end else begin
                for (int b = 0; b < int'(c[17:8]) && !stop; b++) begin
                    exp_src[g] = s + 32'(256 * b);
                    exp_dst[g] = d + 32'(256 * b);
                    if (g == err_at) begin
                        exp_rd = (err_kind == 1); exp_wr = (err_kind == 2);
                        stop = 1;
                    end
                    g++;
                end
                if (!stop && c[31]) begin
                    exp_done = 1; stop = 1;
                end
            end
        end
        exp_n = g;
    endtask

    task automatic put_elem(input int i, input logic [31:0] s, input logic [31:0] d,
                            input logic [31:0] c);
        mem[3*i] = s; mem[3*i+1] = d; mem[3*i+2] = c;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    endtask

    // Run one walk and check its outcome.
    task automatic run_case(input logic [31:0] b, input bit mid_start, input string tag);
        int wait_n;
        cur_base = b;
        model();
        fetch_n = 0; burst_n = 0; done_n = 0; d_dly = 0; m_dly = 0;
        @(negedge clk);
        start = 1'b1; base_addr = b;
        @(negedge clk);
        start = 1'b0; base_addr = $urandom;
        chk(busy == 1'b1, "R2", {tag, " busy after start"}, 32'(busy), 32'h1);
        chk({err_sg, err_rd, err_wr} == 3'b000, "R10",
            {tag, " flags cleared by start"}, 32'({err_sg, err_rd, err_wr}), 32'h0);
        wait_n = 0;
        while (busy && wait_n < 20000) begin
            if (mid_start && wait_n == 7) begin
                start = 1'b1; base_addr = b + 32'h1000;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            wait_n++;
        end
        start = 1'b0;
        repeat (4) @(negedge clk);
        chk(burst_n == exp_n, "R4", {tag, " burst total"}, 32'(burst_n), 32'(exp_n));
        chk(done_n == exp_done, "R5", {tag, " done pulses"}, 32'(done_n), 32'(exp_done));
        chk(err_sg == exp_sg, "R6", {tag, " err_sg"}, 32'(err_sg), 32'(exp_sg));
        chk(err_rd == exp_rd, "R7", {tag, " err_rd"}, 32'(err_rd), 32'(exp_rd));
        chk(err_wr == exp_wr, "R8", {tag, " err_wr"}, 32'(err_wr), 32'(exp_wr));
        chk(!busy && !mv_req && !desc_req, "R10", {tag, " idle after walk"},
            32'({busy, mv_req, desc_req}), 32'h0);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        clear_mem();
        exp_n = 0; err_at = -1; err_kind = 0;
        cur_base = 0; fetch_n = 0; burst_n = 0; done_n = 0; d_dly = 0; m_dly = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({busy, done, err_sg, err_rd, err_wr, desc_req, mv_req} == 7'h0, "R1",
            "reset outputs", 32'({busy, done, err_sg, err_rd, err_wr, desc_req, mv_req}), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed: single burst, end flag, reserved bits set (R3, R5)
        clear_mem(); err_at = -1;
        put_elem(0, 32'h0001_0000, 32'h8000_0000, 32'hFFFC_0100);
        run_case(32'h0000_2000, 0, "R3 single");

        // Directed: largest count 0x3FF00 (R4)
        clear_mem();
        put_elem(0, 32'hFFFF_F000, 32'h1234_5600, 32'h8003_FF00);
        run_case(32'h0000_4000, 0, "R4 maxcount");

        // Directed: zero count after a good element (R6)
        clear_mem();
        put_elem(0, 32'h100, 32'h200, 32'h0000_0200);
        put_elem(1, 32'h300, 32'h400, 32'h8000_0000);
        run_case(32'h0000_6000, 0, "R6 zero");

        // Directed: count off the grid (R6); flags hold until next start (R10)
        clear_mem();
        put_elem(0, 32'h500, 32'h600, 32'h8000_0180);
        run_case(32'h0000_6100, 0, "R6 offgrid");
        repeat (10) @(negedge clk);
        chk(err_sg == 1'b1, "R10", "err_sg holds while idle", 32'(err_sg), 32'h1);

        // Directed: no end flag, walk runs into a zero element (R5, R6)
        clear_mem();
        put_elem(0, 32'hA00, 32'hB00, 32'h0000_0100);
        put_elem(1, 32'hC00, 32'hD00, 32'h0000_0300);
        run_case(32'h0000_7000, 0, "R5 nolast");

        // Directed: read fault at burst 2 and write fault at burst 0 (R7, R8)
        clear_mem();
        put_elem(0, 32'h1000, 32'h2000, 32'h8000_0400);
        err_at = 2; err_kind = 1;
        run_case(32'h0000_8000, 0, "R7 rdfault");
        err_at = 0; err_kind = 2;
        run_case(32'h0000_8000, 0, "R8 wrfault");
        err_at = -1; err_kind = 0;

        // Directed: start while busy is ignored (R9)
        clear_mem();
        put_elem(0, 32'h3000, 32'h4000, 32'h0000_0300);
        put_elem(1, 32'h5000, 32'h6000, 32'h8000_0200);
        run_case(32'h0000_9000, 1, "R9 midstart");

        // Random tables
        for (int t = 0; t < 40; t++) begin
            int ne;
            logic [31:0] c;
            clear_mem();
            ne = 1 + ($urandom % 4);
            for (int e = 0; e < ne; e++) begin
                c = ($urandom & 32'h7FFC_0000) | (32'(1 + ($urandom % 4)) << 8);
                if (($urandom % 10) == 0) c = c | 32'(8'h1 << ($urandom % 8));
                if (e == ne - 1) c = c | 32'h8000_0000;
                put_elem(e, $urandom, $urandom, c);
            end
            if (($urandom % 4) == 0) begin
                err_at = $urandom % 6; err_kind = 1 + ($urandom % 2);
            end else begin
                err_at = -1; err_kind = 0;
            end
            run_case({$urandom, 2'b00}, ($urandom % 5) == 0, "R4 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule